// File: doc/BRIEF.md
# Privilege-Checked Segment Address Decoder

This block is the front end of a 32-bit memory management unit. Each request carries a virtual address, a read/write indication, the current privilege level and the error-level flag. The top three address bits select one of eight fixed regions. The block then checks whether the current privilege may use that region. A permitted access is either translated on the spot, through an unmapped window or an identity map, or handed to an external TLB. The TLB result is passed through.

When the access fails, the block turns the outcome into a 5-bit exception code. In the same cycle it produces the new values of three fault-state registers: the bad virtual address, the page-table context and the entry-high register. The owning core writes these values while the fault pulse is high. The TLB lookup is combinational within the request cycle. All responses, including the fault pulse, appear on registered outputs one clock after the request.

Top module: `segx_front`

## Requirements
- R1: An address with bit 31 clear, presented while `err_level` is 1, is translated to itself with read and write permission. No TLB lookup is made, and `tlb_status` has no effect.
- R2: An address with bit 31 clear, presented while `err_level` is 0, is forwarded to the TLB. On a hit (`tlb_status` 00) the response is OK with `tlb_paddr`, read permission, and write permission equal to `tlb_writable`.
- R3: An address in 0x80000000..0x9FFFFFFF in kernel mode (`req_mode` 00) is translated without the TLB to address minus 0x80000000, with read and write permission.
- R4: An address in 0xA0000000..0xBFFFFFFF in kernel mode is translated without the TLB to address minus 0xA0000000, with read and write permission.
- R5: An address in 0xC0000000..0xDFFFFFFF goes to the TLB in supervisor (01) or kernel mode. An address at 0xE0000000 or above goes to the TLB only in kernel mode.
- R6: An access to a region the current privilege may not use is an address error, with code 4 for a read and 5 for a write. It makes no TLB lookup. `req_mode` 10 and 11 are both user.
- R7: TLB status 01 (no entry) gives code 2 for a read or 3 for a write, with `fault_refill` set. Status 10 (entry not valid) gives the same codes with `fault_refill` clear. Status 11 (write to a clean page) gives code 1.
- R8: On a fault, `badvaddr_nx` equals the address. `context_nx` keeps bits 31:23 of `ctx_cur`, holds address bits 31:13 in bits 22:4, and has bits 3:0 zero.
- R9: On a fault, `entryhi_nx` keeps bits 7:0 of `entryhi_cur`, holds address bits 31:13 in bits 31:13, and has bits 12:8 zero.
- R10: The response to a request appears exactly one cycle later as a single-cycle `resp_valid`. `fault_valid` is high only with `resp_valid` and never together with `resp_ok`. When `resp_ok` is low, the address and permission outputs are zero. When `fault_valid` is low, the code, refill and register outputs are zero. A cycle without a request gives all-zero outputs.
- R11: `tlb_lookup` is high in the request cycle exactly when the access is permitted and needs the TLB. `tlb_vaddr` and `tlb_write` then carry the address and the write flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | 1 = store, 0 = load |
| req_mode | input | 2 | Privilege: 00 kernel, 01 supervisor, 10/11 user |
| err_level | input | 1 | Error-level flag |
| ctx_cur | input | 32 | Current context register value |
| entryhi_cur | input | 32 | Current entry-high register value |
| tlb_lookup | output | 1 | TLB lookup request (combinational) |
| tlb_vaddr | output | 32 | Address sent to the TLB |
| tlb_write | output | 1 | Write flag sent to the TLB |
| tlb_status | input | 2 | TLB outcome: 00 hit, 01 no entry, 10 not valid, 11 clean page |
| tlb_paddr | input | 32 | Physical address from the TLB on a hit |
| tlb_writable | input | 1 | Hit entry permits writes |
| resp_valid | output | 1 | Response pulse |
| resp_ok | output | 1 | Translation succeeded |
| resp_paddr | output | 32 | Physical address |
| resp_rd | output | 1 | Read permitted |
| resp_wr | output | 1 | Write permitted |
| fault_valid | output | 1 | Fault pulse; register updates valid |
| fault_code | output | 5 | Exception code |
| fault_refill | output | 1 | Fault came from a missing TLB entry |
| badvaddr_nx | output | 32 | New bad-address register value |
| context_nx | output | 32 | New context register value |
| entryhi_nx | output | 32 | New entry-high register value |

## Verification
The case hardest to reach from the ports is a TLB outcome that the block must ignore. The bench plays the TLB and drives a failing status even when the address is translated directly or denied. R1, R3, R4 and R6 can only hold if those statuses leave no trace. Random runs mix all four privilege codes with the error-level flag and addresses at region edges such as 0x7FFFFFFF and 0xDFFFFFFF. Each fault is paired with random context and entry-high values, so the preserved bits are seen to survive the register updates.

// File: rtl/segx_pkg.sv
package segx_pkg;

   typedef enum logic [1:0] {
      TLB_HIT   = 2'b00,
      TLB_MISS  = 2'b01,
      TLB_INVAL = 2'b10,
      TLB_CLEAN = 2'b11
   } tlb_stat_e;

   typedef enum logic [1:0] {
      ROUTE_DIRECT = 2'b00,
      ROUTE_TLB    = 2'b01,
      ROUTE_DENY   = 2'b10
   } route_e;

   typedef struct packed {
      logic k_ok;
      logic s_ok;
      logic u_ok;
      logic mapped;
      logic erl_bypass;
   } region_attr_t;

   localparam logic [4:0] EXC_MOD   = 5'd1;
   localparam logic [4:0] EXC_TLB_L = 5'd2;
   localparam logic [4:0] EXC_TLB_S = 5'd3;
   localparam logic [4:0] EXC_ADE_L = 5'd4;
   localparam logic [4:0] EXC_ADE_S = 5'd5;

   // Lower half: all levels, mapped unless error level set.
   // Next quarter: kernel-only windows without mapping.
   // Next eighth: supervisor/kernel mapped; top eighth: kernel mapped.
   function automatic region_attr_t region_attr(input int idx, input int nreg);
      region_attr_t a;
      a = '0;
      if (idx < nreg / 2) begin
         a.k_ok = 1'b1; a.s_ok = 1'b1; a.u_ok = 1'b1;
         a.mapped = 1'b1; a.erl_bypass = 1'b1;
      end else if (idx < (3 * nreg) / 4) begin
         a.k_ok = 1'b1;
      end else if (idx < (7 * nreg) / 8) begin
         a.k_ok = 1'b1; a.s_ok = 1'b1; a.mapped = 1'b1;
      end else begin
         a.k_ok = 1'b1; a.mapped = 1'b1;
      end
      return a;
   endfunction

endpackage

// File: rtl/segx_classify.sv
module segx_classify
   import segx_pkg::*;
#(
   parameter int VA_W     = 32,
   parameter int REG_BITS = 3
)(
   input  logic [VA_W-1:0] vaddr,
   input  logic [1:0]      mode,
   input  logic            erl,
   output route_e          route,
   output logic [VA_W-1:0] direct_paddr
);
   localparam int NREG    = 1 << REG_BITS;
   localparam int SEL_LSB = VA_W - REG_BITS;

   initial begin
      assert (REG_BITS == 3) else $error("segx_classify: REG_BITS must be 3");
      assert (VA_W > REG_BITS) else $error("segx_classify: VA_W too small");
   end

   logic [NREG-1:0] hit;
   region_attr_t    attr [NREG];
   logic [VA_W-1:0] base [NREG];

   generate
      for (genvar r = 0; r < NREG; r++) begin : g_region
         assign hit[r]  = (vaddr[VA_W-1:SEL_LSB] == REG_BITS'(r));
         assign attr[r] = region_attr(r, NREG);
         assign base[r] = attr[r].mapped ? '0 : (VA_W'(r) << SEL_LSB);
      end
   endgenerate

   region_attr_t    sel;
   logic [VA_W-1:0] sel_base;
   logic            allowed;

   always_comb begin
      sel      = '0;
      sel_base = '0;
      for (int r = 0; r < NREG; r++) begin
         if (hit[r]) begin
            sel      = attr[r];
            sel_base = base[r];
         end
      end
      case (mode)
         2'b00:   allowed = sel.k_ok;
         2'b01:   allowed = sel.s_ok;
         default: allowed = sel.u_ok;
      endcase
      if (!allowed)
         route = ROUTE_DENY;
      else if (sel.mapped && !(sel.erl_bypass && erl))
         route = ROUTE_TLB;
      else
         route = ROUTE_DIRECT;
      direct_paddr = vaddr - sel_base;
   end

endmodule

// File: rtl/segx_fault_enc.sv
module segx_fault_enc
   import segx_pkg::*;
#(
   parameter int EXC_W = 5
)(
   input  route_e           route,
   input  logic             write,
   input  logic [1:0]       tlb_status,
   output logic             fault,
   output logic [EXC_W-1:0] code,
   output logic             refill
);
   initial begin
      assert (EXC_W >= 5) else $error("segx_fault_enc: EXC_W must hold 5 bits");
   end

   always_comb begin
      fault  = 1'b0;
      code   = '0;
      refill = 1'b0;
      if (route == ROUTE_DENY) begin
         fault = 1'b1;
         code  = EXC_W'(write ? EXC_ADE_S : EXC_ADE_L);
      end else if (route == ROUTE_TLB) begin
         case (tlb_stat_e'(tlb_status))
            TLB_MISS: begin
               fault  = 1'b1;
               refill = 1'b1;
               code   = EXC_W'(write ? EXC_TLB_S : EXC_TLB_L);
            end
            TLB_INVAL: begin
               fault = 1'b1;
               code  = EXC_W'(write ? EXC_TLB_S : EXC_TLB_L);
            end
            TLB_CLEAN: begin
               fault = 1'b1;
               code  = EXC_W'(EXC_MOD);
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/segx_fault_state.sv
module segx_fault_state #(
   parameter int VA_W     = 32,
   parameter int ASID_W   = 8,
   parameter int VPN2_LSB = 13,
   parameter int CTX_LSB  = 4
)(
   input  logic [VA_W-1:0] vaddr,
   input  logic [VA_W-1:0] ctx_cur,
   input  logic [VA_W-1:0] ehi_cur,
   output logic [VA_W-1:0] badvaddr_nx,
   output logic [VA_W-1:0] context_nx,
   output logic [VA_W-1:0] entryhi_nx
);
   localparam int VPN2_W  = VA_W - VPN2_LSB;
   localparam int CTX_MSB = CTX_LSB + VPN2_W - 1;
   localparam logic [VA_W-1:0] CTX_KEEP  = ~((VA_W'(1) << (CTX_MSB + 1)) - VA_W'(1));
   localparam logic [VA_W-1:0] ASID_KEEP = (VA_W'(1) << ASID_W) - VA_W'(1);

   initial begin
      assert (ASID_W <= VPN2_LSB) else $error("segx_fault_state: ASID overlaps VPN2");
      assert (CTX_MSB < VA_W - 1) else $error("segx_fault_state: context field too wide");
   end

   logic [VA_W-1:0] ctx_field;
   logic [VA_W-1:0] ehi_field;

   always_comb begin
      ctx_field = VA_W'(vaddr[VA_W-1:VPN2_LSB]) << CTX_LSB;
      ehi_field = {vaddr[VA_W-1:VPN2_LSB], {VPN2_LSB{1'b0}}};
      badvaddr_nx = vaddr;
      context_nx  = (ctx_cur & CTX_KEEP) | ctx_field;
      entryhi_nx  = (ehi_cur & ASID_KEEP) | ehi_field;
   end

endmodule

// File: rtl/segx_front.sv
module segx_front
   import segx_pkg::*;
#(
   parameter int VA_W   = 32,
   parameter int ASID_W = 8,
   parameter int EXC_W  = 5
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [VA_W-1:0]  req_vaddr,
   input  logic             req_write,
   input  logic [1:0]       req_mode,
   input  logic             err_level,
   input  logic [VA_W-1:0]  ctx_cur,
   input  logic [VA_W-1:0]  entryhi_cur,
   output logic             tlb_lookup,
   output logic [VA_W-1:0]  tlb_vaddr,
   output logic             tlb_write,
   input  logic [1:0]       tlb_status,
   input  logic [VA_W-1:0]  tlb_paddr,
   input  logic             tlb_writable,
   output logic             resp_valid,
   output logic             resp_ok,
   output logic [VA_W-1:0]  resp_paddr,
   output logic             resp_rd,
   output logic             resp_wr,
   output logic             fault_valid,
   output logic [EXC_W-1:0] fault_code,
   output logic             fault_refill,
   output logic [VA_W-1:0]  badvaddr_nx,
   output logic [VA_W-1:0]  context_nx,
   output logic [VA_W-1:0]  entryhi_nx
);
   initial begin
      assert (VA_W == 32) else $error("segx_front: only 32-bit addresses supported");
   end

   route_e          route;
   logic [VA_W-1:0] direct_pa;
   logic            f_hit;
   logic [EXC_W-1:0] f_code;
   logic            f_refill;
   logic [VA_W-1:0] bva_d, ctx_d, ehi_d;

   segx_classify #(.VA_W(VA_W), .REG_BITS(3)) u_classify (
      .vaddr(req_vaddr), .mode(req_mode), .erl(err_level),
      .route(route), .direct_paddr(direct_pa)
   );

   segx_fault_enc #(.EXC_W(EXC_W)) u_fenc (
      .route(route), .write(req_write), .tlb_status(tlb_status),
      .fault(f_hit), .code(f_code), .refill(f_refill)
   );

   segx_fault_state #(.VA_W(VA_W), .ASID_W(ASID_W)) u_fstate (
      .vaddr(req_vaddr), .ctx_cur(ctx_cur), .ehi_cur(entryhi_cur),
      .badvaddr_nx(bva_d), .context_nx(ctx_d), .entryhi_nx(ehi_d)
   );

   assign tlb_lookup = req_valid && (route == ROUTE_TLB);
   assign tlb_vaddr  = req_vaddr;
   assign tlb_write  = req_write;

   logic            ok_d, wr_d, fault_d;
   logic [VA_W-1:0] pa_d;

   always_comb begin
      ok_d = 1'b0;
      wr_d = 1'b0;
      pa_d = '0;
      if (req_valid && route == ROUTE_DIRECT) begin
         ok_d = 1'b1;
         wr_d = 1'b1;
         pa_d = direct_pa;
      end else if (tlb_lookup && tlb_stat_e'(tlb_status) == TLB_HIT) begin
         ok_d = 1'b1;
         wr_d = tlb_writable;
         pa_d = tlb_paddr;
      end
      fault_d = req_valid && f_hit;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         resp_valid   <= 1'b0;
         resp_ok      <= 1'b0;
         resp_paddr   <= '0;
         resp_rd      <= 1'b0;
         resp_wr      <= 1'b0;
         fault_valid  <= 1'b0;
         fault_code   <= '0;
         fault_refill <= 1'b0;
         badvaddr_nx  <= '0;
         context_nx   <= '0;
         entryhi_nx   <= '0;
      end else begin
         resp_valid   <= req_valid;
         resp_ok      <= ok_d;
         resp_paddr   <= pa_d;
         resp_rd      <= ok_d;
         resp_wr      <= wr_d;
         fault_valid  <= fault_d;
         fault_code   <= fault_d ? f_code : '0;
         fault_refill <= fault_d && f_refill;
         badvaddr_nx  <= fault_d ? bva_d : '0;
         context_nx   <= fault_d ? ctx_d : '0;
         entryhi_nx   <= fault_d ? ehi_d : '0;
      end
   end

   AST_ERL_IDENTITY: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && err_level && !req_vaddr[VA_W-1]) |=> (resp_ok && resp_paddr == $past(req_vaddr))); // R1
   AST_UNMAPPED_NO_TLB: assert property (@(posedge clk) disable iff (!rst_n)
      tlb_lookup |-> (req_vaddr[VA_W-1:VA_W-2] != 2'b10)); // R3
   AST_USER_DENIED: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_mode[1] && req_vaddr[VA_W-1]) |=>
      (fault_valid && (fault_code == EXC_W'(EXC_ADE_L) || fault_code == EXC_W'(EXC_ADE_S)))); // R6
   AST_REFILL_TLB_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      fault_refill |-> (fault_valid && (fault_code == EXC_W'(EXC_TLB_L) || fault_code == EXC_W'(EXC_TLB_S)))); // R7
   AST_BADVADDR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      fault_valid |-> (badvaddr_nx == $past(req_vaddr))); // R8
   AST_ASID_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      fault_valid |-> (entryhi_nx[ASID_W-1:0] == $past(entryhi_cur[ASID_W-1:0]))); // R9
   AST_FAULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      fault_valid |-> (resp_valid && !resp_ok)); // R10

endmodule

// File: tb/segx_front_bench.sv
module segx_front_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_vaddr = '0;
   logic        req_write = 1'b0;
   logic [1:0]  req_mode = 2'b00;
   logic        err_level = 1'b0;
   logic [31:0] ctx_cur = '0;
   logic [31:0] entryhi_cur = '0;
   logic        tlb_lookup;
   logic [31:0] tlb_vaddr;
   logic        tlb_write;
   logic [1:0]  tlb_status = 2'b00;
   logic [31:0] tlb_paddr = '0;
   logic        tlb_writable = 1'b0;
   logic        resp_valid, resp_ok, resp_rd, resp_wr;
   logic [31:0] resp_paddr;
   logic        fault_valid, fault_refill;
   logic [4:0]  fault_code;
   logic [31:0] badvaddr_nx, context_nx, entryhi_nx;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;   // 250 MHz

   segx_front u_segx_front (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
      .req_write(req_write), .req_mode(req_mode), .err_level(err_level),
      .ctx_cur(ctx_cur), .entryhi_cur(entryhi_cur), .tlb_lookup(tlb_lookup),
      .tlb_vaddr(tlb_vaddr), .tlb_write(tlb_write), .tlb_status(tlb_status),
      .tlb_paddr(tlb_paddr), .tlb_writable(tlb_writable), .resp_valid(resp_valid),
      .resp_ok(resp_ok), .resp_paddr(resp_paddr), .resp_rd(resp_rd), .resp_wr(resp_wr),
      .fault_valid(fault_valid), .fault_code(fault_code), .fault_refill(fault_refill),
      .badvaddr_nx(badvaddr_nx), .context_nx(context_nx), .entryhi_nx(entryhi_nx)
   );

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   // Behavioural reference: one request, checked at the TLB port in its
   // own cycle and at the response outputs one cycle later.
   task automatic apply(input bit v, input logic [31:0] a, input bit w, input logic [1:0] m,
                        input bit e, input logic [31:0] ctx, input logic [31:0] ehi,
                        input logic [1:0] st, input logic [31:0] tp, input bit tw);
      int unsigned seg;
      bit kern, sup;
      int route;            // 0 direct, 1 tlb, 2 deny
      string tag;
      bit ok, fl, rf, ewr;
      logic [31:0] pa;
      logic [4:0] code;
      logic [31:0] xb, xc, xe;
      @(negedge clk);
      req_valid = v; req_vaddr = a; req_write = w; req_mode = m; err_level = e;
      ctx_cur = ctx; entryhi_cur = ehi; tlb_status = st; tlb_paddr = tp; tlb_writable = tw;
      seg = a >> 29;
      kern = (m == 2'b00);
      sup  = (m == 2'b01);
      pa = 32'h0; ewr = 0; route = 2; tag = "R6";
      if (seg < 4) begin
         if (e) begin route = 0; pa = a; ewr = 1; tag = "R1"; end
         else begin route = 1; tag = "R2"; end
      end else if (seg == 4) begin
         if (kern) begin route = 0; pa = a - 32'h8000_0000; ewr = 1; tag = "R3"; end
      end else if (seg == 5) begin
         if (kern) begin route = 0; pa = a - 32'hA000_0000; ewr = 1; tag = "R4"; end
      end else if (seg == 6) begin
         if (kern || sup) begin route = 1; tag = "R5"; end
      end else begin
         if (kern) begin route = 1; tag = "R5"; end
      end
      ok = 0; fl = 0; rf = 0; code = 5'd0;
      if (route == 0) ok = 1;
      else if (route == 2) begin fl = 1; code = w ? 5'd5 : 5'd4; end
      else begin
         case (st)
            2'b00: begin ok = 1; pa = tp; ewr = tw; end
            2'b01: begin fl = 1; rf = 1; code = w ? 5'd3 : 5'd2; tag = "R7"; end
            2'b10: begin fl = 1; code = w ? 5'd3 : 5'd2; tag = "R7"; end
            default: begin fl = 1; code = 5'd1; tag = "R7"; end
         endcase
      end
      if (!v) begin ok = 0; fl = 0; rf = 0; code = 0; tag = "R10"; end
      if (!ok) begin pa = 0; ewr = 0; end
      xb = 0; xc = 0; xe = 0;
      if (fl) begin
         xb = a;
         xc = (ctx & 32'hFF80_0000) | ((a >> 9) & 32'h007F_FFF0);
         xe = (ehi & 32'h0000_00FF) | (a & 32'hFFFF_E000);
      end
      #1;
      chk("R11", "tlb_lookup", {31'b0, tlb_lookup}, {31'b0, (v && route == 1)});
      if (v && route == 1) begin
         chk("R11", "tlb_vaddr", tlb_vaddr, a);
         chk("R11", "tlb_write", {31'b0, tlb_write}, {31'b0, w});
      end
      @(posedge clk);
      #1;
      chk("R10", "resp_valid", {31'b0, resp_valid}, {31'b0, v});
      chk(tag, "resp_ok", {31'b0, resp_ok}, {31'b0, ok});
      chk(tag, "resp_paddr", resp_paddr, pa);
      chk(tag, "resp_rd", {31'b0, resp_rd}, {31'b0, ok});
      chk(tag, "resp_wr", {31'b0, resp_wr}, {31'b0, ewr});
      chk(tag, "fault_valid", {31'b0, fault_valid}, {31'b0, fl});
      chk(tag, "fault_code", {27'b0, fault_code}, {27'b0, code});
      chk(tag, "fault_refill", {31'b0, fault_refill}, {31'b0, rf});
      chk("R8", "badvaddr_nx", badvaddr_nx, xb);
      chk("R8", "context_nx", context_nx, xc);
      chk("R9", "entryhi_nx", entryhi_nx, xe);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk("R10", "reset resp_valid", {31'b0, resp_valid}, 32'h0);
      chk("R10", "reset fault_valid", {31'b0, fault_valid}, 32'h0);
      chk("R10", "reset entryhi_nx", entryhi_nx, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: identity with error level, a failing TLB status must not matter
      apply(1, 32'h1234_5678, 1, 2'b10, 1, 32'h0, 32'h0, 2'b01, 32'hDEAD_0000, 0);
      apply(1, 32'h7FFF_FFFF, 0, 2'b00, 1, 32'h0, 32'h0, 2'b11, 32'h0, 0);
      // R2: forwarded, hit passes through
      apply(1, 32'h0040_1000, 0, 2'b10, 0, 32'h0, 32'h0, 2'b00, 32'h0ABC_D123, 0);
      apply(1, 32'h0040_1000, 1, 2'b11, 0, 32'h0, 32'h0, 2'b00, 32'h0001_2000, 1);
      // R3 / R4: kernel unmapped windows, TLB status ignored
      apply(1, 32'h8000_0000, 1, 2'b00, 0, 32'h0, 32'h0, 2'b01, 32'h0, 0);
      apply(1, 32'h9FFF_FFFC, 0, 2'b00, 0, 32'h0, 32'h0, 2'b10, 32'h0, 0);
      apply(1, 32'hA000_0010, 0, 2'b00, 0, 32'h0, 32'h0, 2'b11, 32'h0, 0);
      apply(1, 32'hBFC0_0000, 1, 2'b00, 1, 32'h0, 32'h0, 2'b01, 32'h0, 0);
      // R5: supervisor region and kernel-only mapped region
      apply(1, 32'hDFFF_FFFF, 0, 2'b01, 0, 32'h0, 32'h0, 2'b00, 32'h1111_0000, 1);
      apply(1, 32'hE000_0000, 0, 2'b00, 0, 32'h0, 32'h0, 2'b00, 32'h2222_0000, 0);
      // R6: denied, user code 11, supervisor in kernel-only regions
      apply(1, 32'h8000_1000, 0, 2'b11, 0, 32'h0, 32'hFFFF_FFAB, 2'b00, 32'h0, 1);
      apply(1, 32'hE000_0000, 1, 2'b01, 0, 32'hFFFF_FFFF, 32'h0, 2'b00, 32'h0, 1);
      apply(1, 32'hC000_0000, 0, 2'b10, 1, 32'h1234_5678, 32'h0, 2'b00, 32'h0, 0);
      // R7: each failing TLB outcome, loads and stores
      apply(1, 32'h0000_2000, 0, 2'b10, 0, 32'hA5A5_A5A5, 32'h0000_0042, 2'b01, 32'h0, 0);
      apply(1, 32'h0000_2000, 1, 2'b10, 0, 32'hA5A5_A5A5, 32'h0000_0042, 2'b01, 32'h0, 0);
      apply(1, 32'hC123_4567, 1, 2'b01, 0, 32'h0, 32'hFFFF_FF00, 2'b10, 32'h0, 0);
      apply(1, 32'hF000_E000, 1, 2'b00, 0, 32'h0, 32'h1234_5699, 2'b11, 32'h0, 0);
      // R10: idle cycles
      apply(0, 32'h8000_0000, 1, 2'b10, 0, 32'h0, 32'h0, 2'b01, 32'h0, 0);
      apply(0, 32'h0000_0000, 0, 2'b00, 0, 32'h0, 32'h0, 2'b00, 32'h0, 0);

      for (int i = 0; i < 800; i++) begin
         logic [31:0] a;
         a = $urandom();
         if (i % 5 == 0) a = {a[31:29], (a[0] ? 29'h1FFF_FFFF : 29'h0)};
         apply(($urandom() % 8) != 0, a, $urandom() % 2, 2'($urandom()), ($urandom() % 4) == 0,
               $urandom(), $urandom(), 2'($urandom()), $urandom(), $urandom() % 2);
      end
      finish_run();
   end

endmodule